// File: doc/BRIEF.md
# Dual-Pipe In-Order Issue Unit

The block is the issue stage of a small SIMD coprocessor. Fixed 32-bit instructions arrive one per cycle into a two-slot window. Each slot is decoded into one of two pipe classes: the even pipe takes arithmetic work (floating point, integer, 128-bit logic, arithmetic byte ops) and the odd pipe takes memory and control work (load, store, branch, branch hint, byte shuffle). Each cycle the unit issues the older slot alone, issues both slots together, or issues nothing. It never reorders the stream and has no prediction.

A scoreboard holds one busy bit for each of the 128 architectural registers. An instruction with a destination sets its bit when it issues. The bit clears when a writeback strobe naming that register arrives from either pipe. Any instruction whose sources or destination are busy waits. A redirect input empties the window in the cycle it is asserted.

Top module: `dual_issue_unit`

## Requirements
- R1: Instruction format. Bits [31:24] are the opcode, [23:17] the destination register, [16:10] source A and [9:3] source B. Opcode bit 31 = 0 selects the even (arithmetic) pipe and bit 31 = 1 selects the odd (memory/control) pipe. An odd-class instruction with bit 30 = 1 has no destination, and issuing it marks no register busy. Every instruction reads sources A and B.
- R2: When the older slot holds a hazard-free even-class instruction, it is presented on the even port. A hazard-free odd-class older instruction is presented on the odd port. A transfer happens on a cycle where valid and ready are both high.
- R3: When the older slot is even-class and the younger slot is odd-class, and both are hazard-free and both ports are ready, both instructions issue in the same cycle and the window empties.
- R4: If the older slot is odd-class, or both slots are even-class, only the older instruction issues in that cycle. The younger one issues in a later cycle, in program order.
- R5: The younger instruction does not pair when it reads or writes the older instruction's destination register.
- R6: An instruction waits while any register it reads or writes is marked busy. Issuing an instruction that has a destination marks that register busy from the next cycle.
- R7: A writeback strobe on either pipe clears the named busy bit at the clock edge. A waiting instruction can be presented in the cycle after that edge.
- R8: A port that is not ready blocks only its own class. The instruction stays presented and unchanged. A younger instruction is never presented ahead of an older one that has not issued. If the odd port is not ready, the even half of a pair issues alone.
- R9: While redirect is high, no instruction is presented and no fetch is accepted. Both window slots are empty from the next cycle.
- R10: After reset the window is empty, no port is valid, fetch ready is high and every register is free.
- R11: Fetch ready is low while both window slots are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Flushes the fetch window and blocks issue this cycle |
| fetch_valid_i | input | 1 | Fetch instruction present |
| fetch_instr_i | input | 32 | Fetched instruction |
| fetch_ready_o | output | 1 | Window can accept an instruction |
| even_valid_o | output | 1 | Instruction presented to the arithmetic pipe |
| even_instr_o | output | 32 | Arithmetic pipe instruction |
| even_ready_i | input | 1 | Arithmetic pipe accepts |
| odd_valid_o | output | 1 | Instruction presented to the memory/control pipe |
| odd_instr_o | output | 32 | Memory/control pipe instruction |
| odd_ready_i | input | 1 | Memory/control pipe accepts |
| wb_even_valid_i | input | 1 | Arithmetic pipe writeback strobe |
| wb_even_reg_i | input | 7 | Register freed by the arithmetic pipe |
| wb_odd_valid_i | input | 1 | Memory/control pipe writeback strobe |
| wb_odd_reg_i | input | 7 | Register freed by the memory/control pipe |

## Verification
The assertions check these on every cycle:
- the window never holds more than two entries;
- a redirect empties the window and presents nothing;
- only arithmetic-class code reaches the even port;
- a dual issue always has the arithmetic-then-memory class order and no dependency between the two;
- nothing is presented while one of its registers is busy;
- an issued destination is busy in the following cycle.

Only the directed scenarios show that program order holds through stalls, that a blocked port holds its instruction steady, and that the cycle in which a writeback releases a stall is the right one. The same applies to the behaviour of destination-less stores and to fetch back-pressure.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int INSTR_W  = 32;
  localparam int REG_W    = 7;
  localparam int NUM_REGS = 1 << REG_W;
  localparam int SLOTS    = 2;
  localparam int CNT_W    = $clog2(SLOTS + 1);

  typedef enum logic {
    PIPE_EVEN = 1'b0,
    PIPE_ODD  = 1'b1
  } pipe_e;

  typedef struct packed {
    logic [INSTR_W-1:0] raw;
    pipe_e              pipe;
    logic               has_dst;
    logic [REG_W-1:0]   dst;
    logic [REG_W-1:0]   src_a;
    logic [REG_W-1:0]   src_b;
  } dec_t;
endpackage

// File: rtl/issue_decode.sv
module issue_decode
  import issue_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  always_comb begin
    dec_o.raw     = instr_i;
    dec_o.pipe    = instr_i[31] ? PIPE_ODD : PIPE_EVEN;
    // odd-class with bit 30 set: store/branch style, no destination
    dec_o.has_dst = !(instr_i[31] && instr_i[30]);
    dec_o.dst     = instr_i[23:17];
    dec_o.src_a   = instr_i[16:10];
    dec_o.src_b   = instr_i[9:3];
  end
endmodule

// File: rtl/issue_window.sv
module issue_window
  import issue_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               push_i,
  input  logic [INSTR_W-1:0] push_data_i,
  input  logic [CNT_W-1:0]   pop_cnt_i,
  output logic               ready_o,
  output logic [SLOTS-1:0]   valid_o,
  output logic [INSTR_W-1:0] slot_o [SLOTS]
);
  logic [CNT_W-1:0]   cnt_q, cnt_d, rem;
  logic [INSTR_W-1:0] slot_q [SLOTS];
  logic [INSTR_W-1:0] slot_d [SLOTS];
  logic               push_fire;

  assign ready_o   = (cnt_q != CNT_W'(SLOTS)) && !flush_i;
  assign push_fire = push_i && ready_o;

  always_comb begin
    slot_d = slot_q;
    rem    = cnt_q - pop_cnt_i;
    if (pop_cnt_i == CNT_W'(1)) slot_d[0] = slot_q[1];
    if (push_fire) begin
      if (rem == '0) slot_d[0] = push_data_i;
      else           slot_d[1] = push_data_i;
    end
    cnt_d = rem + CNT_W'(push_fire);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_out
      assign valid_o[g] = cnt_q > CNT_W'(g);
      assign slot_o[g]  = slot_q[g];
    end
  endgenerate

  p_cnt_max_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SLOTS));
  p_pop_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_cnt_i <= cnt_q);
  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0);
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import issue_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_even_i,
  input  logic [RW-1:0]   set_even_reg_i,
  input  logic            set_odd_i,
  input  logic [RW-1:0]   set_odd_reg_i,
  input  logic            clr_even_i,
  input  logic [RW-1:0]   clr_even_reg_i,
  input  logic            clr_odd_i,
  input  logic [RW-1:0]   clr_odd_reg_i,
  output logic [NREG-1:0] busy_o
);
  logic [NREG-1:0] busy_q;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_bit
      logic set_b, clr_b;
      assign set_b = (set_even_i && set_even_reg_i == RW'(g)) ||
                     (set_odd_i  && set_odd_reg_i  == RW'(g));
      assign clr_b = (clr_even_i && clr_even_reg_i == RW'(g)) ||
                     (clr_odd_i  && clr_odd_reg_i  == RW'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    busy_q[g] <= 1'b0;
        else if (set_b) busy_q[g] <= 1'b1;   // set wins
        else if (clr_b) busy_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign busy_o = busy_q;

  p_set_even_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_even_i |=> busy_q[$past(set_even_reg_i)]);
  p_set_odd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_odd_i |=> busy_q[$past(set_odd_reg_i)]);
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_even_i && !set_even_i && !set_odd_i) |=> !busy_q[$past(clr_even_reg_i)]);
endmodule

// File: rtl/issue_select.sv
module issue_select
  import issue_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [SLOTS-1:0]   valid_i,
  input  dec_t               older_i,
  input  dec_t               younger_i,
  input  logic [NUM_REGS-1:0] busy_i,
  input  logic               even_ready_i,
  input  logic               odd_ready_i,
  output logic               even_valid_o,
  output logic [INSTR_W-1:0] even_instr_o,
  output logic               odd_valid_o,
  output logic [INSTR_W-1:0] odd_instr_o,
  output logic [CNT_W-1:0]   pop_cnt_o,
  output logic               set_even_o,
  output logic [REG_W-1:0]   set_even_reg_o,
  output logic               set_odd_o,
  output logic [REG_W-1:0]   set_odd_reg_o
);
  function automatic logic hazard(dec_t d, logic [NUM_REGS-1:0] b);
    return b[d.src_a] || b[d.src_b] || (d.has_dst && b[d.dst]);
  endfunction

  logic o_ok, o_even, o_odd, o_fire, y_dep, y_cand, y_fire;

  always_comb begin
    o_ok   = valid_i[0] && !flush_i && !hazard(older_i, busy_i);
    o_even = o_ok && older_i.pipe == PIPE_EVEN;
    o_odd  = o_ok && older_i.pipe == PIPE_ODD;
    o_fire = (o_even && even_ready_i) || (o_odd && odd_ready_i);
    y_dep  = older_i.has_dst &&
             (younger_i.src_a == older_i.dst || younger_i.src_b == older_i.dst ||
              (younger_i.has_dst && younger_i.dst == older_i.dst));
    // younger rides only behind an even-class older that is actually leaving
    y_cand = valid_i[1] && o_even && even_ready_i && younger_i.pipe == PIPE_ODD &&
             !hazard(younger_i, busy_i) && !y_dep;
    y_fire = y_cand && odd_ready_i;
  end

  assign even_valid_o   = o_even;
  assign even_instr_o   = older_i.raw;
  assign odd_valid_o    = o_odd || y_cand;
  assign odd_instr_o    = o_odd ? older_i.raw : younger_i.raw;
  assign pop_cnt_o      = CNT_W'(o_fire) + CNT_W'(y_fire);
  assign set_even_o     = o_even && even_ready_i && older_i.has_dst;
  assign set_even_reg_o = older_i.dst;
  assign set_odd_o      = (o_odd && odd_ready_i && older_i.has_dst) ||
                          (y_fire && younger_i.has_dst);
  assign set_odd_reg_o  = o_odd ? older_i.dst : younger_i.dst;

  p_even_class_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    even_valid_o |-> even_instr_o[31] == 1'b0);
  p_odd_class_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_valid_o |-> odd_instr_o[31] == 1'b1);
  p_pair_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_cnt_o == CNT_W'(2) |-> (older_i.pipe == PIPE_EVEN && younger_i.pipe == PIPE_ODD));
  p_pair_indep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_cnt_o == CNT_W'(2) && older_i.has_dst) |->
      (younger_i.src_a != older_i.dst && younger_i.src_b != older_i.dst));
endmodule

// File: rtl/dual_issue_unit.sv
module dual_issue_unit
  import issue_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               redirect_i,
  input  logic               fetch_valid_i,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  output logic               fetch_ready_o,
  output logic               even_valid_o,
  output logic [INSTR_W-1:0] even_instr_o,
  input  logic               even_ready_i,
  output logic               odd_valid_o,
  output logic [INSTR_W-1:0] odd_instr_o,
  input  logic               odd_ready_i,
  input  logic               wb_even_valid_i,
  input  logic [REG_W-1:0]   wb_even_reg_i,
  input  logic               wb_odd_valid_i,
  input  logic [REG_W-1:0]   wb_odd_reg_i
);
  logic [SLOTS-1:0]    win_valid;
  logic [INSTR_W-1:0]  win_slot [SLOTS];
  dec_t                dec [SLOTS];
  logic [CNT_W-1:0]    pop_cnt;
  logic [NUM_REGS-1:0] busy;
  logic                set_even, set_odd;
  logic [REG_W-1:0]    set_even_reg, set_odd_reg;

  issue_window u_win (
    .clk_i, .rst_ni,
    .flush_i     (redirect_i),
    .push_i      (fetch_valid_i),
    .push_data_i (fetch_instr_i),
    .pop_cnt_i   (pop_cnt),
    .ready_o     (fetch_ready_o),
    .valid_o     (win_valid),
    .slot_o      (win_slot)
  );

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
      issue_decode u_dec (.instr_i(win_slot[g]), .dec_o(dec[g]));
    end
  endgenerate

  issue_select u_sel (
    .clk_i, .rst_ni,
    .flush_i        (redirect_i),
    .valid_i        (win_valid),
    .older_i        (dec[0]),
    .younger_i      (dec[1]),
    .busy_i         (busy),
    .even_ready_i,
    .odd_ready_i,
    .even_valid_o,
    .even_instr_o,
    .odd_valid_o,
    .odd_instr_o,
    .pop_cnt_o      (pop_cnt),
    .set_even_o     (set_even),
    .set_even_reg_o (set_even_reg),
    .set_odd_o      (set_odd),
    .set_odd_reg_o  (set_odd_reg)
  );

  issue_scoreboard #(.NREG(NUM_REGS)) u_sb (
    .clk_i, .rst_ni,
    .set_even_i     (set_even),
    .set_even_reg_i (set_even_reg),
    .set_odd_i      (set_odd),
    .set_odd_reg_i  (set_odd_reg),
    .clr_even_i     (wb_even_valid_i),
    .clr_even_reg_i (wb_even_reg_i),
    .clr_odd_i      (wb_odd_valid_i),
    .clr_odd_reg_i  (wb_odd_reg_i),
    .busy_o         (busy)
  );

  p_redirect_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> (!even_valid_o && !odd_valid_o && !fetch_ready_o));
  p_even_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    even_valid_o |-> (!busy[even_instr_o[16:10]] && !busy[even_instr_o[9:3]] &&
                      !busy[even_instr_o[23:17]]));
  p_odd_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_valid_o |-> (!busy[odd_instr_o[16:10]] && !busy[odd_instr_o[9:3]]));
  p_full_backpressure_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&win_valid) |-> !fetch_ready_o);
endmodule

// File: tb/dual_issue_unit_test.sv
module dual_issue_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        redirect_i = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_instr_i = '0;
  logic        fetch_ready_o;
  logic        even_valid_o, odd_valid_o;
  logic [31:0] even_instr_o, odd_instr_o;
  logic        even_ready_i = 1'b0, odd_ready_i = 1'b0;
  logic        wb_even_valid_i = 1'b0, wb_odd_valid_i = 1'b0;
  logic [6:0]  wb_even_reg_i = '0, wb_odd_reg_i = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_issue_unit uut (
    .clk_i(clk), .rst_ni, .redirect_i, .fetch_valid_i, .fetch_instr_i, .fetch_ready_o,
    .even_valid_o, .even_instr_o, .even_ready_i, .odd_valid_o, .odd_instr_o, .odd_ready_i,
    .wb_even_valid_i, .wb_even_reg_i, .wb_odd_valid_i, .wb_odd_reg_i
  );

  localparam logic [7:0] OP_ALU   = 8'h10;
  localparam logic [7:0] OP_LOAD  = 8'h80;
  localparam logic [7:0] OP_STORE = 8'hC0;

  function automatic logic [31:0] mk(logic [7:0] op, logic [6:0] d, logic [6:0] a, logic [6:0] b);
    return {op, d, a, b, 3'b000};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(logic [31:0] ins);
    fetch_valid_i = 1'b1;
    fetch_instr_i = ins;
    tick();
    fetch_valid_i = 1'b0;
  endtask

  task automatic wb(logic ev, logic [6:0] er, logic ov, logic [6:0] orr);
    wb_even_valid_i = ev; wb_even_reg_i = er;
    wb_odd_valid_i  = ov; wb_odd_reg_i  = orr;
    tick();
    wb_even_valid_i = 1'b0; wb_odd_valid_i = 1'b0;
  endtask

  task automatic ready(logic e, logic o);
    even_ready_i = e; odd_ready_i = o; #1;
  endtask

  task automatic t_reset();
    chk("R10", "even valid in reset", 32'(even_valid_o), 0);
    chk("R10", "odd valid in reset", 32'(odd_valid_o), 0);
    rst_ni = 1'b1;
    tick();
    chk("R10", "fetch ready after reset", 32'(fetch_ready_o), 1);
    chk("R10", "even valid after reset", 32'(even_valid_o), 0);
  endtask

  task automatic t_single_and_stall();
    logic [31:0] a1, a2;
    a1 = mk(OP_ALU, 7'd5, 7'd1, 7'd2);
    a2 = mk(OP_ALU, 7'd6, 7'd5, 7'd2);
    ready(1, 1);
    push(a1); #1;
    chk("R2", "single alu valid", 32'(even_valid_o), 1);
    chk("R2", "single alu instr", even_instr_o, a1);
    chk("R2", "odd idle", 32'(odd_valid_o), 0);
    tick(); #1;
    chk("R2", "window empty after issue", 32'(even_valid_o), 0);
    push(a2); #1;
    chk("R6", "dependent stalls", 32'(even_valid_o), 0);
    tick(); #1;
    chk("R6", "still stalled", 32'(even_valid_o), 0);
    wb_even_valid_i = 1'b1; wb_even_reg_i = 7'd5; #1;
    chk("R7", "busy until edge", 32'(even_valid_o), 0);
    tick();
    wb_even_valid_i = 1'b0; #1;
    chk("R7", "released after writeback", 32'(even_valid_o), 1);
    chk("R7", "released instr", even_instr_o, a2);
    tick();
    wb(1, 7'd6, 0, 7'd0);
  endtask

  task automatic t_pair();
    logic [31:0] a, l;
    a = mk(OP_ALU, 7'd10, 7'd1, 7'd2);
    l = mk(OP_LOAD, 7'd11, 7'd3, 7'd4);
    ready(0, 0);
    push(a); push(l);
    ready(1, 1);
    chk("R3", "pair even valid", 32'(even_valid_o), 1);
    chk("R3", "pair odd valid", 32'(odd_valid_o), 1);
    chk("R3", "pair odd instr", odd_instr_o, l);
    tick(); #1;
    chk("R3", "window empty after pair", 32'(even_valid_o | odd_valid_o), 0);
    wb(1, 7'd10, 1, 7'd11);
  endtask

  task automatic t_mem_first();
    logic [31:0] s, a, c;
    s = mk(OP_STORE, 7'd20, 7'd1, 7'd2);
    a = mk(OP_ALU, 7'd12, 7'd1, 7'd2);
    c = mk(OP_ALU, 7'd13, 7'd20, 7'd2);
    ready(0, 0);
    push(s); push(a);
    ready(1, 1);
    chk("R4", "odd older alone", 32'(odd_valid_o), 1);
    chk("R4", "even younger held", 32'(even_valid_o), 0);
    tick(); #1;
    chk("R4", "younger next cycle", 32'(even_valid_o), 1);
    chk("R4", "younger instr", even_instr_o, a);
    tick();
    push(c); #1;
    chk("R1", "store marks no dst busy", 32'(even_valid_o), 1);
    tick();
    wb(1, 7'd12, 0, 7'd0);
    wb(1, 7'd13, 0, 7'd0);
  endtask

  task automatic t_two_alu();
    logic [31:0] a, b;
    a = mk(OP_ALU, 7'd14, 7'd1, 7'd2);
    b = mk(OP_ALU, 7'd15, 7'd1, 7'd2);
    ready(0, 0);
    push(a); push(b);
    ready(1, 1);
    chk("R4", "two alu: first", even_instr_o, a);
    chk("R4", "two alu: odd idle", 32'(odd_valid_o), 0);
    tick(); #1;
    chk("R4", "two alu: second", even_instr_o, b);
    tick();
    wb(1, 7'd14, 1, 7'd15);
  endtask

  task automatic t_dependent_pair();
    logic [31:0] a, l;
    a = mk(OP_ALU, 7'd16, 7'd1, 7'd2);
    l = mk(OP_LOAD, 7'd17, 7'd16, 7'd4);
    ready(0, 0);
    push(a); push(l);
    ready(1, 1);
    chk("R5", "dependent younger not paired", 32'(odd_valid_o), 0);
    tick(); #1;
    chk("R5", "younger waits on older dst", 32'(odd_valid_o), 0);
    wb(1, 7'd16, 0, 7'd0); #1;
    chk("R5", "younger after writeback", odd_instr_o, l);
    tick();
    wb(0, 7'd0, 1, 7'd17);
  endtask

  task automatic t_blocked();
    logic [31:0] a, l, a2, l2;
    a  = mk(OP_ALU, 7'd18, 7'd1, 7'd2);
    l  = mk(OP_LOAD, 7'd19, 7'd3, 7'd4);
    a2 = mk(OP_ALU, 7'd21, 7'd1, 7'd2);
    l2 = mk(OP_LOAD, 7'd22, 7'd3, 7'd4);
    ready(0, 0);
    push(a); push(l);
    ready(1, 0);
    tick(); #1;
    chk("R8", "odd blocked: load held", 32'(odd_valid_o), 1);
    chk("R8", "odd blocked: load instr", odd_instr_o, l);
    chk("R8", "odd blocked: alu left", 32'(even_valid_o), 0);
    tick(); #1;
    chk("R8", "odd blocked: stable", odd_instr_o, l);
    ready(1, 1);
    tick();
    push(a2); ready(0, 0); push(l2);
    ready(0, 1);
    chk("R8", "no bypass of blocked older", 32'(odd_valid_o), 0);
    chk("R8", "older still presented", even_instr_o, a2);
    ready(1, 1);
    tick(); #1;
    chk("R8", "window drains", 32'(even_valid_o | odd_valid_o), 0);
    wb(1, 7'd18, 1, 7'd19);
    wb(1, 7'd21, 1, 7'd22);
  endtask

  task automatic t_redirect_full();
    ready(0, 0);
    push(mk(OP_ALU, 7'd30, 7'd1, 7'd2));
    push(mk(OP_LOAD, 7'd31, 7'd3, 7'd4)); #1;
    chk("R11", "fetch ready low when full", 32'(fetch_ready_o), 0);
    redirect_i = 1'b1;
    ready(1, 1);
    chk("R9", "no even issue on redirect", 32'(even_valid_o), 0);
    chk("R9", "no odd issue on redirect", 32'(odd_valid_o), 0);
    tick();
    redirect_i = 1'b0; #1;
    chk("R9", "window empty after redirect", 32'(even_valid_o | odd_valid_o), 0);
    chk("R9", "fetch ready after redirect", 32'(fetch_ready_o), 1);
    push(mk(OP_ALU, 7'd30, 7'd1, 7'd2)); #1;
    chk("R9", "flushed regs not busy", 32'(even_valid_o), 1);
    tick();
    wb(1, 7'd30, 0, 7'd0);
  endtask

  initial begin
    @(negedge clk); #1;
    t_reset();
    t_single_and_stall();
    t_pair();
    t_mem_first();
    t_two_alu();
    t_dependent_pair();
    t_blocked();
    t_redirect_full();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule